// File: doc/BRIEF.md
# Clocked Serial Memory Streamer

This block sends the contents of a 128-byte memory array out over one open-drain data line. The rate is set by a dedicated stream clock that the block samples in its own system clock domain. After reset the line stays released for nine stream-clock rising edges while the block synchronizes. From the tenth edge on, one bit goes out per rising edge. Each byte is sent most significant bit first and is followed by a released filler bit. When the last address has been sent, the pointer returns to address zero and the stream continues without end.

A separate two-wire bus clock is normally held high. One falling edge on it moves the block into bidirectional mode, and the block never leaves that mode on its own. In bidirectional mode the stream clock has no effect and the data line is left released. A mode output tells a bus slave elsewhere on the chip that it now owns the shared line. Only a reset brings streaming back. Both clocks pass through a two-flop synchronizer and then a glitch filter, so a level counts only after it has held for a set number of system clocks.

The array itself sits next to the block and has a combinational read port. The block presents the address of the byte it is sending and reads that byte's data back.

Top module: `mbs_streamer`

## Requirements
- R1: While reset is held and right after it is released, `mode_bidir_o` is 0, `mem_addr_o` is 0 and `sda_oe_o` is 0.
- R2: For the first nine filtered rising edges of the stream clock, `sda_oe_o` stays 0 (line released).
- R3: The tenth filtered rising edge launches bit 7 (the MSB) of the byte at address 0.
- R4: Each later rising edge launches the next bit of the current byte, from bit 7 down to bit 0. `sda_oe_o` is 1 exactly when the launched bit is 0, so the line level equals the bit.
- R5: After bit 0, one more rising edge launches a null bit with `sda_oe_o` = 0. The rising edge after the null bit starts the next address.
- R6: After the null bit of address 127, the next byte comes from address 0.
- R7: A filtered falling edge on the bus clock sets `mode_bidir_o` to 1. From then on `sda_oe_o` is 0, and stream-clock edges change neither `sda_oe_o` nor `mem_addr_o`.
- R8: Once `mode_bidir_o` is 1, it stays 1 whatever either clock does, until reset.
- R9: A level on either clock input that holds for fewer than FILT_CYC system clocks is ignored. It neither advances the stream nor changes the mode.
- R10: During streaming, `mem_addr_o` gives the address of the byte whose bits are being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strm_clk_i | input | 1 | Stream clock, asynchronous to clk |
| bus_scl_i | input | 1 | Two-wire bus clock; idle high |
| mem_data_i | input | 8 | Data of the byte at `mem_addr_o` |
| mem_addr_o | output | 7 | Address of the byte being streamed |
| sda_oe_o | output | 1 | Drive the data line low when 1; released otherwise |
| mode_bidir_o | output | 1 | 1 once bidirectional mode has been entered |

## Verification
The bench uses the default parameters: DEPTH=128, BYTE_W=8, INIT_CLKS=9, FILT_CYC=4, SYNC_STAGES=2. With a 128-byte array, one complete pass plus the wrap to address 0 fits in about 1200 stream-clock pulses of random width. With FILT_CYC=4, a two-cycle glitch falls clearly under the filter threshold, while pulses of twelve cycles or more are always accepted. Array contents and pulse widths come from a fixed seed. Directed cases cover the ignored glitches, the mode switch, the mode holding after the switch, and a second initialization after reset.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic {MODE_STREAM = 1'b0, MODE_BIDIR = 1'b1} mbs_mode_e;

  // pointer advance with wrap at the array depth
  function automatic int unsigned wrap_inc(input int unsigned a, input int unsigned depth);
    return (a + 1 >= depth) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/mbs_sync_filter.sv
module mbs_sync_filter #(
  parameter int unsigned STAGES   = 2,
  parameter int unsigned HOLD     = 4,
  parameter bit          RST_VAL  = 1'b0,
  parameter bit          RISE_EVT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic evt
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [STAGES-1:0] sh_q;
  logic              lvl_q;
  logic [CW-1:0]     cnt_q;
  logic              synced;
  logic              flip;

  assign synced = sh_q[STAGES-1];
  assign flip   = (synced != lvl_q) && (cnt_q == CW'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= {STAGES{RST_VAL}};
      lvl_q <= RST_VAL;
      cnt_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], din};
      if (synced == lvl_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        lvl_q <= synced;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  generate
    if (RISE_EVT) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= flip && !lvl_q;
      end
    end else begin : g_fall
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= flip && lvl_q;
      end
    end
  endgenerate
endmodule

// File: rtl/mbs_bit_seq.sv
module mbs_bit_seq #(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned INIT_CLKS = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  output logic [$clog2(DEPTH)-1:0] addr,
  output logic [$clog2(BYTE_W+1)-1:0] bit_idx,
  output logic                     init_done,
  output logic                     null_phase
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned IW = $clog2(BYTE_W + 1);
  localparam int unsigned PW = $clog2(INIT_CLKS + 1);

  logic [PW-1:0] pre_q;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return AW'(mbs_pkg::wrap_inc(int'(a), DEPTH));
  endfunction

  assign null_phase = init_done && (bit_idx == IW'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      init_done <= 1'b0;
      bit_idx   <= '0;
      addr      <= '0;
    end else if (step) begin
      if (!init_done) begin
        if (pre_q == PW'(INIT_CLKS)) begin
          init_done <= 1'b1;
          bit_idx   <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end else if (bit_idx == IW'(BYTE_W)) begin
        bit_idx <= '0;
        addr    <= next_addr(addr);
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbs_streamer.sv
module mbs_streamer #(
  parameter int unsigned DEPTH       = 128,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned INIT_CLKS   = 9,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strm_clk_i,
  input  logic              bus_scl_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              sda_oe_o,
  output logic              mode_bidir_o
);
  import mbs_pkg::*;
  localparam int unsigned IW = $clog2(BYTE_W + 1);

  // named internal events for the checker
  logic              strm_rise;
  logic              scl_fall;
  logic              step;
  logic              init_done;
  logic              null_phase;
  logic [IW-1:0]     bit_idx;
  mbs_mode_e         mode_q;

  function automatic logic msb_first(input logic [BYTE_W-1:0] d, input logic [IW-1:0] idx);
    logic b;
    b = 1'b1;
    for (int i = 0; i < BYTE_W; i++) begin
      if (idx == IW'(i)) b = d[BYTE_W-1-i];
    end
    return b;
  endfunction

  mbs_sync_filter #(.STAGES(SYNC_STAGES), .HOLD(FILT_CYC), .RST_VAL(1'b0), .RISE_EVT(1'b1))
    u_strm_filt (.clk(clk), .rst_n(rst_n), .din(strm_clk_i), .evt(strm_rise));

  mbs_sync_filter #(.STAGES(SYNC_STAGES), .HOLD(FILT_CYC), .RST_VAL(1'b1), .RISE_EVT(1'b0))
    u_scl_filt (.clk(clk), .rst_n(rst_n), .din(bus_scl_i), .evt(scl_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MODE_STREAM;
    else if (scl_fall) mode_q <= MODE_BIDIR;
  end

  assign step = strm_rise && (mode_q == MODE_STREAM);

  mbs_bit_seq #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .INIT_CLKS(INIT_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .addr(mem_addr_o),
    .bit_idx(bit_idx), .init_done(init_done), .null_phase(null_phase)
  );

  assign mode_bidir_o = (mode_q == MODE_BIDIR);
  assign sda_oe_o     = init_done && !mode_bidir_o && !null_phase &&
                        !msb_first(mem_data_i, bit_idx);
endmodule

// File: rtl/mbs_streamer_chk.sv
module mbs_streamer_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DEPTH  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe_o,
  input logic              mode_bidir_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              step,
  input logic              init_done,
  input logic              null_phase
);
  a_r2_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !sda_oe_o);

  a_r5_null_released: assert property (@(posedge clk) disable iff (!rst_n)
    null_phase |-> !sda_oe_o);

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && null_phase && mem_addr_o == ADDR_W'(DEPTH - 1)) |=> (mem_addr_o == '0));

  a_r10_addr_moves_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(mem_addr_o));

  a_r7_bidir_released: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bidir_o |-> !sda_oe_o);

  a_r8_bidir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bidir_o |=> mode_bidir_o);
endmodule

bind mbs_streamer mbs_streamer_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .mode_bidir_o(mode_bidir_o),
  .mem_addr_o(mem_addr_o), .step(step), .init_done(init_done), .null_phase(null_phase)
);

// File: tb/mbs_streamer_bench.sv
module mbs_streamer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strm = 1'b0;
  logic       scl = 1'b1;
  logic [7:0] mem [128];
  logic [7:0] mem_data;
  logic [6:0] mem_addr;
  logic       sda_oe, mode_bidir;
  int         n_chk = 0, n_err = 0, cyc = 0;
  logic       s_oe, s_mode;
  logic [6:0] s_addr;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;
  assign mem_data = mem[mem_addr];

  mbs_streamer u_mbs_streamer (
    .clk(clk), .rst_n(rst_n), .strm_clk_i(strm), .bus_scl_i(scl),
    .mem_data_i(mem_data), .mem_addr_o(mem_addr), .sda_oe_o(sda_oe), .mode_bidir_o(mode_bidir)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // expected line level for stream position p (0 = MSB of address 0)
  function automatic int exp_line(input int p);
    int idx = p % 9;
    if (idx == 8) return 1;
    return int'(mem[(p / 9) % 128][7 - idx]);
  endfunction

  function automatic int exp_addr(input int p);
    return (p / 9) % 128;
  endfunction

  // one stream-clock pulse, outputs sampled at end of the high phase
  task automatic tick();
    strm = 1'b1;
    repeat (12 + $urandom_range(0, 8)) @(negedge clk);
    s_oe = sda_oe; s_addr = mem_addr; s_mode = mode_bidir;
    strm = 1'b0;
    repeat (12 + $urandom_range(0, 8)) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; strm = 1'b0; scl = 1'b1;
    repeat (4) @(negedge clk);
    check(sda_oe == 0 && mode_bidir == 0 && mem_addr == 0, "R1 in reset",
          {sda_oe, mode_bidir, mem_addr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sda_oe == 0 && mode_bidir == 0 && mem_addr == 0, "R1 after reset",
          {sda_oe, mode_bidir, mem_addr}, 0);
  endtask

  task automatic do_init();
    for (int i = 1; i <= 9; i++) begin
      tick();
      check(s_oe == 0, "R2 quiet init", s_oe, 0);
    end
    tick();
    check(int'(!s_oe) == int'(mem[0][7]), "R3 first MSB", !s_oe, mem[0][7]);
    check(s_addr == 0, "R10 addr at start", s_addr, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < 128; a++) mem[a] = 8'($urandom);
    mem[0] = 8'h5A; mem[127] = 8'hC3;
    do_reset();
    do_init();
    for (int p = 1; p < 9 * 130; p++) begin
      if (p == 20) begin // R9: short glitch on stream clock
        strm = 1'b1; repeat (2) @(negedge clk); strm = 1'b0;
        repeat (16) @(negedge clk);
      end
      if (p == 40) begin // R9: short glitch on bus clock
        scl = 1'b0; repeat (2) @(negedge clk); scl = 1'b1;
        repeat (16) @(negedge clk);
        check(mode_bidir == 0, "R9 bus glitch ignored", mode_bidir, 0);
      end
      tick();
      if (p % 9 == 8)
        check(s_oe == 0, "R5 null released", s_oe, 0);
      else if (p / 9 == 128)
        check(int'(!s_oe) == exp_line(p), "R6 wrapped data", !s_oe, exp_line(p));
      else
        check(int'(!s_oe) == exp_line(p), p == 21 ? "R9 stream glitch" : "R4 data bit",
              !s_oe, exp_line(p));
      check(int'(s_addr) == exp_addr(p), p / 9 == 128 ? "R6 wrap addr" : "R10 addr",
            s_addr, exp_addr(p));
    end
    // R7: bus clock falling edge
    scl = 1'b0;
    repeat (15) @(negedge clk);
    check(mode_bidir == 1, "R7 mode switch", mode_bidir, 1);
    check(sda_oe == 0, "R7 line released", sda_oe, 0);
    for (int i = 0; i < 5; i++) begin
      tick();
      check(s_oe == 0, "R7 stream ignored oe", s_oe, 0);
      check(int'(s_addr) == exp_addr(9 * 130 - 1), "R7 addr frozen", s_addr, exp_addr(9 * 130 - 1));
    end
    scl = 1'b1; repeat (15) @(negedge clk);
    scl = 1'b0; repeat (15) @(negedge clk);
    scl = 1'b1; repeat (15) @(negedge clk);
    check(mode_bidir == 1, "R8 mode sticky", mode_bidir, 1);
    // R8: only reset returns to streaming, then a full re-initialization
    do_reset();
    check(mode_bidir == 0, "R8 reset clears mode", mode_bidir, 0);
    do_init();
    tick();
    check(int'(!s_oe) == exp_line(1), "R4 after reinit", !s_oe, exp_line(1));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 180000);
    n_err++; n_chk++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule